// File: doc/BRIEF.md
# Accumulator Read Scaler and Saturating Limiter

This block forms the values that an accumulator read places on two 24-bit data buses, X and Y, during a parallel move. Each bus has its own source selector. A source is either a whole 56-bit accumulator (A or B) or one of that accumulator's three sub-registers: low word, high word or 8-bit extension. A shared two-bit scaling mode applies to whole-accumulator reads. The value is shifted one bit left, shifted one bit right, or left as it is. The shifted value is then checked against the 24-bit fractional range. If it does not fit, a saturation constant goes on the bus in place of the data.

Sub-register reads skip scaling and saturation. The accumulator inputs are only read, so saturation changes what goes on the bus and never the stored value. Both buses and a one-cycle limit indication are registered, so results appear one clock after the source, mode and accumulator inputs are presented. Both buses can carry either accumulator in the same cycle.

Top module: `acc_rd_path`

## Requirements
- R1: While the synchronous active-high reset is asserted, both buses and the limit indication are registered as zero.
- R2: Outputs appear one clock after their inputs. A whole-accumulator read with scaling mode 0 (no shift) and an in-range value puts accumulator bits [47:24] on the bus.
- R3: Scaling mode 1 shifts the whole accumulator one bit left, filling bit 0 with zero, before the range check and bus selection.
- R4: Scaling mode 2 shifts the whole accumulator one bit right, copying bit 55 into the vacated top bit, before the range check and bus selection.
- R5: The range check uses the scaled value and never the raw value. A scaled value is out of range when its bits [55:47] are not all equal.
- R6: An out-of-range scaled value with bit 55 clear sends 0x7FFFFF. An out-of-range scaled value with bit 55 set sends 0x800000.
- R7: Source codes are: 0 is the whole A, 1 is the whole B, 2/3/4 are A bits [23:0], [47:24] and [55:48], 5/6/7 are the same fields of B. Sub-register reads are never scaled or saturated. An extension read returns the 8 bits sign-extended to 24.
- R8: The X and Y buses are selected, scaled and limited independently, and either may carry A or B in the same cycle as the other.
- R9: The limit indication is high for exactly those output cycles in which at least one bus carries a saturation constant in place of data.
- R10: Scaling mode 3 is treated as no shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_a | input | 56 | Current contents of accumulator A |
| acc_b | input | 56 | Current contents of accumulator B |
| scale_mode | input | 2 | 0 no shift, 1 left, 2 right, 3 no shift |
| x_src | input | 3 | Source code for the X bus |
| y_src | input | 3 | Source code for the Y bus |
| x_bus | output | 24 | Registered X bus value |
| y_bus | output | 24 | Registered Y bus value |
| limit_hit | output | 1 | Registered: a bus carried a saturation constant |

## Verification
Whole-accumulator reads are applied with values on each side of both range edges: just inside and just outside the positive limit, and just inside and just outside the negative limit. These show whether the range test and the choice of constant are right. The same magnitudes are then read under left and right scaling. A value that fits only before the shift, or only after it, exposes a check made at the wrong point or a wrong fill bit. Sub-register reads of out-of-range accumulators show that sub-register reads are never scaled or saturated. Reads where X and Y carry different accumulators with different outcomes separate the two lanes and show that the limit flag ORs them.

// File: rtl/acc_rd_pkg.sv
package acc_rd_pkg;

    parameter int unsigned WORD_W  = 24;
    parameter int unsigned EXT_W   = 8;
    localparam int unsigned ACC_W   = EXT_W + 2 * WORD_W;
    localparam int unsigned GUARD_W = EXT_W + 1;
    localparam int unsigned SRC_W   = 3;
    localparam int unsigned MODE_W  = 2;
    localparam int unsigned LANES   = 2;

    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [MODE_W-1:0] {
        SCL_NONE  = 2'd0,
        SCL_LEFT  = 2'd1,
        SCL_RIGHT = 2'd2,
        SCL_RSVD  = 2'd3
    } scale_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_ACC_A = 3'd0,
        SRC_ACC_B = 3'd1,
        SRC_A_LO  = 3'd2,
        SRC_A_HI  = 3'd3,
        SRC_A_EXT = 3'd4,
        SRC_B_LO  = 3'd5,
        SRC_B_HI  = 3'd6,
        SRC_B_EXT = 3'd7
    } src_e;

    typedef struct packed {
        word_t data;
        logic  sat;
    } lane_t;

    function automatic word_t pos_limit();
        return {1'b0, {(WORD_W-1){1'b1}}};
    endfunction

    function automatic word_t neg_limit();
        return {1'b1, {(WORD_W-1){1'b0}}};
    endfunction

    function automatic word_t ext_field(input acc_t v);
        return {{(WORD_W-EXT_W){v[ACC_W-1]}}, v[ACC_W-1 -: EXT_W]};
    endfunction

endpackage

// File: rtl/acc_rd_scaler.sv
module acc_rd_scaler
    import acc_rd_pkg::*;
(
    input  acc_t   acc_in,
    input  scale_e mode,
    output acc_t   acc_out
);

    always_comb begin
        case (mode)
            SCL_LEFT:  acc_out = {acc_in[ACC_W-2:0], 1'b0};
            SCL_RIGHT: acc_out = {acc_in[ACC_W-1], acc_in[ACC_W-1:1]};
            default:   acc_out = acc_in;
        endcase
    end

endmodule

// File: rtl/acc_rd_limiter.sv
module acc_rd_limiter
    import acc_rd_pkg::*;
(
    input  acc_t  scaled,
    output lane_t res
);

    logic [GUARD_W-1:0] guard;
    logic               fits;

    always_comb begin
        guard = scaled[ACC_W-1 -: GUARD_W];
        fits  = (guard == '0) || (guard == '1);
        res.sat = !fits;
        if (fits)
            res.data = scaled[2*WORD_W-1 -: WORD_W];
        else if (scaled[ACC_W-1])
            res.data = neg_limit();
        else
            res.data = pos_limit();
    end

endmodule

// File: rtl/acc_rd_lane.sv
module acc_rd_lane
    import acc_rd_pkg::*;
(
    input  acc_t   acc_a,
    input  acc_t   acc_b,
    input  src_e   src,
    input  scale_e mode,
    output lane_t  res
);

    acc_t  whole;
    acc_t  scaled;
    lane_t limited;
    logic  is_whole;

    always_comb begin
        is_whole = (src == SRC_ACC_A) || (src == SRC_ACC_B);
        whole    = (src == SRC_ACC_B) ? acc_b : acc_a;
    end

    acc_rd_scaler u_scale (
        .acc_in  (whole),
        .mode    (mode),
        .acc_out (scaled)
    );

    acc_rd_limiter u_limit (
        .scaled (scaled),
        .res    (limited)
    );

    always_comb begin
        res.sat = 1'b0;
        case (src)
            SRC_A_LO:  res.data = acc_a[WORD_W-1:0];
            SRC_A_HI:  res.data = acc_a[2*WORD_W-1 -: WORD_W];
            SRC_A_EXT: res.data = ext_field(acc_a);
            SRC_B_LO:  res.data = acc_b[WORD_W-1:0];
            SRC_B_HI:  res.data = acc_b[2*WORD_W-1 -: WORD_W];
            SRC_B_EXT: res.data = ext_field(acc_b);
            default:   res.data = limited.data;
        endcase
        if (is_whole)
            res.sat = limited.sat;
    end

endmodule

// File: rtl/acc_rd_path.sv
module acc_rd_path
    import acc_rd_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [acc_rd_pkg::ACC_W-1:0]   acc_a,
    input  logic [acc_rd_pkg::ACC_W-1:0]   acc_b,
    input  logic [acc_rd_pkg::MODE_W-1:0]  scale_mode,
    input  logic [acc_rd_pkg::SRC_W-1:0]   x_src,
    input  logic [acc_rd_pkg::SRC_W-1:0]   y_src,
    output logic [acc_rd_pkg::WORD_W-1:0]  x_bus,
    output logic [acc_rd_pkg::WORD_W-1:0]  y_bus,
    output logic                           limit_hit
);

    src_e   lane_src [LANES];
    lane_t  lane_res [LANES];
    scale_e mode;
    logic   any_sat;

    assign mode        = scale_e'(scale_mode);
    assign lane_src[0] = src_e'(x_src);
    assign lane_src[1] = src_e'(y_src);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        acc_rd_lane u_lane (
            .acc_a (acc_a),
            .acc_b (acc_b),
            .src   (lane_src[g]),
            .mode  (mode),
            .res   (lane_res[g])
        );
    end

    always_comb begin
        any_sat = 1'b0;
        for (int i = 0; i < LANES; i++)
            any_sat = any_sat | lane_res[i].sat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_bus     <= '0;
            y_bus     <= '0;
            limit_hit <= 1'b0;
        end else begin
            x_bus     <= lane_res[0].data;
            y_bus     <= lane_res[1].data;
            limit_hit <= any_sat;
        end
    end

endmodule

// File: rtl/acc_rd_path_chk.sv
module acc_rd_path_chk
    import acc_rd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ACC_W-1:0]   acc_a,
    input logic [ACC_W-1:0]   acc_b,
    input logic [MODE_W-1:0]  scale_mode,
    input logic [SRC_W-1:0]   x_src,
    input logic [SRC_W-1:0]   y_src,
    input logic [WORD_W-1:0]  x_bus,
    input logic [WORD_W-1:0]  y_bus,
    input logic               limit_hit
);

    localparam logic [WORD_W-1:0] POS_K = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_K = {1'b1, {(WORD_W-1){1'b0}}};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (x_bus == '0 && y_bus == '0 && !limit_hit));

    // R2
    inrange_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (y_src == 3'd1 && scale_mode == 2'd0 &&
         (acc_b[ACC_W-1 -: GUARD_W] == '0 || acc_b[ACC_W-1 -: GUARD_W] == '1))
        |=> y_bus == $past(acc_b[2*WORD_W-1 -: WORD_W]));

    // R6
    pos_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (x_src == 3'd0 && scale_mode == 2'd0 && !acc_a[ACC_W-1] &&
         acc_a[ACC_W-1 -: GUARD_W] != '0)
        |=> x_bus == POS_K);

    // R7
    sub_hi_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (x_src == 3'd3) |=> x_bus == $past(acc_a[2*WORD_W-1 -: WORD_W]));

    // R9
    limit_const_chk: assert property (@(posedge clk) disable iff (rst)
        limit_hit |-> (x_bus == POS_K || x_bus == NEG_K ||
                       y_bus == POS_K || y_bus == NEG_K));

    // R9
    sub_no_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (x_src >= 3'd2 && y_src >= 3'd2) |=> !limit_hit);

endmodule

bind acc_rd_path acc_rd_path_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_a      (acc_a),
    .acc_b      (acc_b),
    .scale_mode (scale_mode),
    .x_src      (x_src),
    .y_src      (y_src),
    .x_bus      (x_bus),
    .y_bus      (y_bus),
    .limit_hit  (limit_hit)
);

// File: tb/acc_rd_path_test.sv
module acc_rd_path_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [55:0] acc_a = '0;
    logic [55:0] acc_b = '0;
    logic [1:0]  scale_mode = '0;
    logic [2:0]  x_src = '0;
    logic [2:0]  y_src = '0;
    logic [23:0] x_bus;
    logic [23:0] y_bus;
    logic        limit_hit;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    acc_rd_path uut (
        .clk(clk), .rst(rst), .acc_a(acc_a), .acc_b(acc_b),
        .scale_mode(scale_mode), .x_src(x_src), .y_src(y_src),
        .x_bus(x_bus), .y_bus(y_bus), .limit_hit(limit_hit)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [55:0] a, input logic [55:0] b,
                                  input logic [2:0] s, input logic [1:0] m,
                                  output logic [23:0] d, output logic sat);
        logic [55:0] w, v;
        sat = 1'b0;
        case (s)
            3'd2: begin d = a[23:0];  return; end
            3'd3: begin d = a[47:24]; return; end
            3'd4: begin d = {{16{a[55]}}, a[55:48]}; return; end
            3'd5: begin d = b[23:0];  return; end
            3'd6: begin d = b[47:24]; return; end
            3'd7: begin d = {{16{b[55]}}, b[55:48]}; return; end
            default: ;
        endcase
        w = (s == 3'd1) ? b : a;
        if (m == 2'd1)      v = w << 1;
        else if (m == 2'd2) v = $signed(w) >>> 1;
        else                v = w;
        sat = !(v[55:47] == 9'h000 || v[55:47] == 9'h1FF);
        d = sat ? (v[55] ? 24'h800000 : 24'h7FFFFF) : v[47:24];
    endfunction

    task automatic apply(input string req, input logic [55:0] a, input logic [55:0] b,
                         input logic [2:0] xs, input logic [2:0] ys, input logic [1:0] m);
        logic [23:0] ex, ey;
        logic sx, sy;
        acc_a = a; acc_b = b; x_src = xs; y_src = ys; scale_mode = m;
        model(a, b, xs, m, ex, sx);
        model(a, b, ys, m, ey, sy);
        @(negedge clk);
        check({req, " x_bus"}, x_bus, ex);
        check({req, " y_bus"}, y_bus, ey);
        check({req, " limit_hit"}, {23'd0, limit_hit}, {23'd0, sx | sy});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        acc_a = 56'h00_800000_000000; x_src = 3'd0; y_src = 3'd0;
        repeat (3) @(negedge clk);
        check("R1 x_bus", x_bus, 24'h0);
        check("R1 y_bus", y_bus, 24'h0);
        check("R1 limit_hit", {23'd0, limit_hit}, 24'h0);
        rst = 1'b0;
    endtask

    task automatic t_no_shift();
        apply("R2 pos in range", 56'h00_7FFFFF_FFFFFF, 56'h00_123456_789ABC, 3'd0, 3'd1, 2'd0);
        apply("R2 neg in range", 56'hFF_800000_000000, 56'hFF_C00000_000001, 3'd0, 3'd1, 2'd0);
        apply("R10 mode3 as none", 56'h00_7FFFFF_FFFFFF, 56'hFF_800000_000000, 3'd0, 3'd1, 2'd3);
    endtask

    task automatic t_limits();
        apply("R6 pos edge out", 56'h00_800000_000000, 56'h00_100000_000000, 3'd0, 3'd1, 2'd0);
        apply("R6 neg edge out", 56'hFF_7FFFFF_FFFFFF, 56'h00_000001_000000, 3'd0, 3'd1, 2'd0);
        apply("R5 large ext", 56'h7F_000000_000000, 56'h80_FFFFFF_FFFFFF, 3'd0, 3'd1, 2'd0);
    endtask

    task automatic t_left();
        apply("R3 left fits", 56'h00_3FFFFF_FFFFFF, 56'hFF_C00000_000000, 3'd0, 3'd1, 2'd1);
        apply("R3 left sat", 56'h00_400000_000000, 56'hFF_BFFFFF_FFFFFF, 3'd0, 3'd1, 2'd1);
        apply("R3 left lsb", 56'h00_000000_800001, 56'h00_000001_000000, 3'd0, 3'd1, 2'd1);
    endtask

    task automatic t_right();
        apply("R4 right fits", 56'h00_800000_000000, 56'hFF_7FFFFF_FFFFFE, 3'd0, 3'd1, 2'd2);
        apply("R4 right sat", 56'h02_000000_000000, 56'hFC_000000_000000, 3'd0, 3'd1, 2'd2);
        apply("R5 right after", 56'h01_000000_000000, 56'hFE_FFFFFF_FFFFFF, 3'd0, 3'd1, 2'd2);
    endtask

    task automatic t_subregs();
        apply("R7 A lo/hi", 56'h7F_ABCDEF_123456, 56'h00_0, 3'd2, 3'd3, 2'd1);
        apply("R7 A ext", 56'h85_800000_000000, 56'h00_0, 3'd4, 3'd4, 2'd2);
        apply("R7 B lo/hi", 56'h00_0, 56'h80_123456_FEDCBA, 3'd5, 3'd6, 2'd1);
        apply("R7 B ext", 56'h00_0, 56'h7A_000000_000000, 3'd7, 3'd7, 2'd2);
    endtask

    task automatic t_dual();
        apply("R8 x A sat y B pass", 56'h00_900000_000000, 56'h00_123456_000000, 3'd0, 3'd1, 2'd0);
        apply("R8 x B y A", 56'h00_123456_000000, 56'hF0_000000_000000, 3'd1, 3'd0, 2'd0);
        apply("R8 same acc", 56'h00_300000_000000, 56'h00_0, 3'd0, 3'd0, 2'd1);
        apply("R9 y only sat", 56'h00_0, 56'h00_800000_000000, 3'd3, 3'd1, 2'd0);
        apply("R9 none sat", 56'h00_0, 56'h00_100000_000000, 3'd3, 3'd1, 2'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_no_shift();
        t_limits();
        t_left();
        t_right();
        t_subregs();
        t_dual();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule